// File: doc/BRIEF.md
# Framed Serial Register Access Slave

This block parses a byte stream from a UART receiver core and gives a remote host read and write access to a small set of internal registers. Every host frame opens with the sync byte 0xA5, followed by a command byte. The slave answers reads through a byte handshake to a UART transmitter core. Write frames and control frames must carry an inverted-sum checksum. A frame whose checksum is wrong is dropped.

Three pieces of control state sit beside the register file. A write lock is engaged from reset. A two-way channel select drives an output pin. A soft-reset request leaves the block as a one-cycle pulse. The block also watches the raw receive line. If the line holds one level for too long, the parser abandons any partly received frame, so a host that lost alignment can start again.

Top module: `serial_regacc_slave`

## Requirements
- R1: While waiting for a frame, any received byte other than 0xA5 is ignored, and a frame that follows such bytes is handled normally.
- R2: A command byte with bit 7 clear reads the register at address bits 6:0. The reply carries B data bytes, most significant first, followed by the checksum. The checksum is the bitwise inverse of the 8-bit wrapping sum of 0xA5, the command and the data bytes. For address a below NUM_REGS, B = (a mod 4) + 1. After reset all registers read zero.
- R3: A read of an address at or above NUM_REGS returns one 0x00 data byte followed by its checksum.
- R4: A command byte with bit 7 set writes to address bits 6:0. The frame carries B data bytes, most significant first, then a checksum computed as in R2. B is 1 for an unmapped address, and such a write changes nothing.
- R5: Writes take effect only while writes are enabled. `wr_enabled` is 0 after reset.
- R6: A write or control frame with a wrong checksum changes no register, no lock state and no channel state.
- R7: Command 0xEA with data 0xE5 enables writes, and with data 0xDC disables them. For example, A5 EA E5 carries checksum 0x8B.
- R8: Command 0xEA with data 0x5A sets `chan_b` to 0. With data 0xA5 it sets `chan_b` to 1. `chan_b` is 0 after reset.
- R9: Command 0xEA with data 0x96 raises `soft_rst_req` for exactly one cycle, in the cycle after the checksum byte is accepted.
- R10: If `rx_line` holds one level for STUCK_CYCLES cycles, a partly received frame is abandoned and the parser waits for 0xA5 again. Register contents are kept.
- R11: `tx_byte` stays stable while `tx_valid` is high and `tx_ready` is low. A reply byte is consumed only when both are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Raw serial receive level, already synchronized, used only for stuck detection |
| rx_valid | input | 1 | One-cycle strobe for a received byte |
| rx_byte | input | 8 | Received byte |
| tx_ready | input | 1 | Transmitter can accept a byte |
| tx_valid | output | 1 | A reply byte is offered |
| tx_byte | output | 8 | Reply byte |
| wr_enabled | output | 1 | Write lock state (1 = writes allowed) |
| chan_b | output | 1 | Channel select (0 = A, 1 = B) |
| soft_rst_req | output | 1 | One-cycle soft-reset request |

## Verification
The hardest situation to reach is the stuck-line resync. It needs a frame halted in mid-payload, then a silence longer than the timeout, then a fresh frame that would be misparsed if the old one were still pending. The bench sends a write header and one data byte to a two-byte register, then holds the line. It then sends a complete write to the same register and reads it back. Any leftover parser state makes that readback fail. Bad checksums and writes under lock are mixed into a seeded random stream, and every read is compared against a bench model.

// File: rtl/sra_pkg.sv
package sra_pkg;
    localparam logic [7:0] SYNC_BYTE   = 8'hA5;
    localparam logic [7:0] SPECIAL_CMD = 8'hEA;
    localparam logic [7:0] OP_UNLOCK   = 8'hE5;
    localparam logic [7:0] OP_LOCK     = 8'hDC;
    localparam logic [7:0] OP_CHAN_A   = 8'h5A;
    localparam logic [7:0] OP_CHAN_B   = 8'hA5;
    localparam logic [7:0] OP_SOFT_RST = 8'h96;

    typedef enum logic [2:0] {
        PS_SYNC, PS_CMD, PS_DATA, PS_CHECK, PS_REPLY
    } parse_st_e;

    typedef enum logic [1:0] {
        TX_IDLE, TX_DATA, TX_CK
    } reply_st_e;

    // Payload length in bytes for an address; unmapped addresses use one byte.
    function automatic logic [2:0] frame_bytes(input logic [6:0] addr, input int nregs);
        if (int'(addr) < nregs) return 3'(addr[1:0]) + 3'd1;
        return 3'd1;
    endfunction
endpackage

// File: rtl/sra_line_watch.sv
module sra_line_watch #(
    parameter int STUCK_CYCLES = 457500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line,
    output logic timeout
);
    localparam int CW = $clog2(STUCK_CYCLES + 1);
    localparam logic [CW-1:0] LIM = CW'(STUCK_CYCLES);

    typedef struct packed {
        logic          line;
        logic [CW-1:0] cnt;
        logic          to;
    } watch_s;

    watch_s q, d;

    always_comb begin
        d      = q;
        d.line = line;
        d.to   = 1'b0;
        if (line != q.line) begin
            d.cnt = '0;
        end else begin
            if (q.cnt != LIM) d.cnt = q.cnt + 1'b1;
            if (q.cnt == LIM - 1'b1) d.to = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.line <= 1'b1;
            q.cnt  <= '0;
            q.to   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign timeout = q.to;

    p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        q.to |=> !q.to);
    p_edge_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (line != q.line) |=> !q.to);
endmodule

// File: rtl/sra_regfile.sv
module sra_regfile #(
    parameter int NUM_REGS = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [6:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic [6:0]  rd_addr,
    output logic [31:0] rd_data
);
    logic [31:0] word [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        localparam int NB = (g % 4) + 1;
        localparam int W  = 8 * NB;
        logic [W-1:0] r_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r_q <= '0;
            else if (wr_en && wr_addr == 7'(g)) r_q <= wr_data[W-1:0];
        end
        assign word[g] = 32'(r_q);
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_addr == 7'(i)) rd_data = word[i];
        end
    end
endmodule

// File: rtl/sra_reply_tx.sv
module sra_reply_tx
    import sra_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic [31:0] load_data,
    input  logic [2:0]  load_nbytes,
    input  logic [7:0]  load_sum,
    output logic        busy,
    input  logic        tx_ready,
    output logic        tx_valid,
    output logic [7:0]  tx_byte
);
    typedef struct packed {
        reply_st_e   ph;
        logic [31:0] sh;
        logic [2:0]  left;
        logic [7:0]  sum;
    } reply_s;

    reply_s q, d;

    assign tx_valid = (q.ph != TX_IDLE);
    assign busy     = tx_valid;
    assign tx_byte  = (q.ph == TX_CK) ? ~q.sum : q.sh[31:24];

    always_comb begin
        d = q;
        if (q.ph == TX_IDLE) begin
            if (load) begin
                d.ph   = TX_DATA;
                d.sh   = load_data << {(3'd4 - load_nbytes), 3'b000};
                d.left = load_nbytes;
                d.sum  = load_sum;
            end
        end else if (tx_ready) begin
            if (q.ph == TX_DATA) begin
                d.sum  = q.sum + q.sh[31:24];
                d.sh   = q.sh << 8;
                d.left = q.left - 3'd1;
                if (q.left == 3'd1) d.ph = TX_CK;
            end else begin
                d.ph = TX_IDLE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.ph   <= TX_IDLE;
            q.sh   <= '0;
            q.left <= '0;
            q.sum  <= '0;
        end else begin
            q <= d;
        end
    end

    p_hold_byte_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte)));
endmodule

// File: rtl/serial_regacc_slave.sv
module serial_regacc_slave
    import sra_pkg::*;
#(
    parameter int NUM_REGS     = 8,
    parameter int STUCK_CYCLES = 457500
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_line,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    input  logic       tx_ready,
    output logic       tx_valid,
    output logic [7:0] tx_byte,
    output logic       wr_enabled,
    output logic       chan_b,
    output logic       soft_rst_req
);
    typedef struct packed {
        parse_st_e   st;
        logic [7:0]  cmd;
        logic [7:0]  sum;
        logic [31:0] data;
        logic [2:0]  left;
        logic        wr_en;
        logic        chan_b;
        logic        rst_req;
    } parse_s;

    parse_s q, d;

    logic        line_to;
    logic        tx_busy;
    logic        reg_we;
    logic        reply_ld;
    logic [31:0] rd_data;
    logic [2:0]  reply_nb;

    sra_line_watch #(.STUCK_CYCLES(STUCK_CYCLES)) u_watch (
        .clk     (clk),
        .rst_n   (rst_n),
        .line    (rx_line),
        .timeout (line_to)
    );

    sra_regfile #(.NUM_REGS(NUM_REGS)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_we),
        .wr_addr (q.cmd[6:0]),
        .wr_data (q.data),
        .rd_addr (rx_byte[6:0]),
        .rd_data (rd_data)
    );

    assign reply_nb = frame_bytes(rx_byte[6:0], NUM_REGS);

    sra_reply_tx u_reply (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (reply_ld),
        .load_data   (rd_data),
        .load_nbytes (reply_nb),
        .load_sum    (q.sum + rx_byte),
        .busy        (tx_busy),
        .tx_ready    (tx_ready),
        .tx_valid    (tx_valid),
        .tx_byte     (tx_byte)
    );

    always_comb begin
        d         = q;
        d.rst_req = 1'b0;
        reg_we    = 1'b0;
        reply_ld  = 1'b0;
        if (line_to && q.st != PS_REPLY) begin
            d.st = PS_SYNC;
        end else begin
            case (q.st)
                PS_SYNC: begin
                    if (rx_valid && rx_byte == SYNC_BYTE) begin
                        d.st  = PS_CMD;
                        d.sum = SYNC_BYTE;
                    end
                end
                PS_CMD: begin
                    if (rx_valid) begin
                        d.cmd  = rx_byte;
                        d.sum  = q.sum + rx_byte;
                        d.data = '0;
                        if (rx_byte == SPECIAL_CMD) begin
                            d.left = 3'd1;
                            d.st   = PS_DATA;
                        end else if (rx_byte[7]) begin
                            d.left = reply_nb;
                            d.st   = PS_DATA;
                        end else begin
                            reply_ld = 1'b1;
                            d.st     = PS_REPLY;
                        end
                    end
                end
                PS_DATA: begin
                    if (rx_valid) begin
                        d.data = {q.data[23:0], rx_byte};
                        d.sum  = q.sum + rx_byte;
                        d.left = q.left - 3'd1;
                        if (q.left == 3'd1) d.st = PS_CHECK;
                    end
                end
                PS_CHECK: begin
                    if (rx_valid) begin
                        d.st = PS_SYNC;
                        if (rx_byte == ~q.sum) begin
                            if (q.cmd == SPECIAL_CMD) begin
                                case (q.data[7:0])
                                    OP_UNLOCK:   d.wr_en   = 1'b1;
                                    OP_LOCK:     d.wr_en   = 1'b0;
                                    OP_CHAN_A:   d.chan_b  = 1'b0;
                                    OP_CHAN_B:   d.chan_b  = 1'b1;
                                    OP_SOFT_RST: d.rst_req = 1'b1;
                                    default: ;
                                endcase
                            end else begin
                                reg_we = q.wr_en;
                            end
                        end
                    end
                end
                PS_REPLY: begin
                    if (!tx_busy) d.st = PS_SYNC;
                end
                default: d.st = PS_SYNC;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st      <= PS_SYNC;
            q.cmd     <= '0;
            q.sum     <= '0;
            q.data    <= '0;
            q.left    <= '0;
            q.wr_en   <= 1'b0;
            q.chan_b  <= 1'b0;
            q.rst_req <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign wr_enabled   = q.wr_en;
    assign chan_b       = q.chan_b;
    assign soft_rst_req = q.rst_req;

    p_resync_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (line_to && q.st != PS_REPLY) |=> (q.st == PS_SYNC));
    p_rst_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        q.rst_req |=> !q.rst_req);
    p_bad_ck_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == PS_CHECK && rx_valid && rx_byte != ~q.sum)
        |=> ($stable(q.wr_en) && $stable(q.chan_b) && !q.rst_req));
    p_reply_no_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == PS_REPLY) |-> !reg_we);
endmodule

// File: tb/serial_regacc_slave_bench.sv
module serial_regacc_slave_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NREGS      = 8;
    localparam int STUCK      = 50;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_line = 1'b1;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       tx_ready = 1'b0;
    logic       tx_valid;
    logic [7:0] tx_byte;
    logic       wr_enabled;
    logic       chan_b;
    logic       soft_rst_req;

    int total = 0;
    int fails = 0;
    logic [31:0] model [NREGS];
    bit model_wen = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_regacc_slave #(.NUM_REGS(NREGS), .STUCK_CYCLES(STUCK)) u_serial_regacc_slave (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .tx_ready(tx_ready), .tx_valid(tx_valid),
        .tx_byte(tx_byte), .wr_enabled(wr_enabled), .chan_b(chan_b),
        .soft_rst_req(soft_rst_req)
    );

    function automatic int nb_of(input int a);
        return (a < NREGS) ? (a % 4) + 1 : 1;
    endfunction

    function automatic logic [31:0] mask_of(input int a);
        return (nb_of(a) == 4) ? 32'hFFFF_FFFF : ((32'd1 << (8 * nb_of(a))) - 32'd1);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        rx_byte  = b;
        rx_valid = 1'b1;
        rx_line  = ~rx_line;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic do_write(input int a, input logic [31:0] v, input bit bad);
        logic [7:0] s;
        logic [7:0] c;
        s = 8'hA5;
        send_byte(8'hA5);
        c = 8'h80 | 8'(a);
        send_byte(c);
        s = s + c;
        for (int i = nb_of(a) - 1; i >= 0; i--) begin
            send_byte(v[8*i +: 8]);
            s = s + v[8*i +: 8];
        end
        send_byte(bad ? ~s ^ 8'h24 : ~s);
        if (!bad && model_wen && a < NREGS) model[a] = v & mask_of(a);
    endtask

    task automatic do_special(input logic [7:0] op, input bit bad);
        logic [7:0] s;
        s = 8'hA5 + 8'hEA + op;
        send_byte(8'hA5);
        send_byte(8'hEA);
        send_byte(op);
        send_byte(bad ? ~s ^ 8'h01 : ~s);
        if (!bad) begin
            if (op == 8'hE5) model_wen = 1'b1;
            if (op == 8'hDC) model_wen = 1'b0;
        end
    endtask

    task automatic do_read(input int a, input string req);
        logic [39:0] got;
        logic [39:0] exp;
        logic [31:0] val;
        logic [7:0]  s;
        logic [7:0]  held;
        bit          stalled;
        int          n;
        int          cnt;
        int          guard;
        n   = nb_of(a);
        val = (a < NREGS) ? model[a] : 32'h0;
        s   = 8'hA5 + 8'(a);
        exp = '0;
        for (int i = n - 1; i >= 0; i--) begin
            exp = {exp[31:0], val[8*i +: 8]};
            s   = s + val[8*i +: 8];
        end
        exp = {exp[31:0], ~s};
        send_byte(8'hA5);
        send_byte(8'(a));
        got = '0; cnt = 0; guard = 0; stalled = 1'b0; held = 8'h00;
        while (cnt < n + 1 && guard < 100) begin
            if (stalled) chk(tx_valid && tx_byte == held, "R11 byte held under stall", {56'h0, tx_byte}, {56'h0, held});
            tx_ready = ($urandom % 3) != 0;
            stalled  = tx_valid && !tx_ready;
            held     = tx_byte;
            if (tx_valid && tx_ready) begin
                got = {got[31:0], tx_byte};
                cnt++;
            end
            @(negedge clk);
            guard++;
        end
        tx_ready = 1'b0;
        chk(cnt == n + 1 && got == exp, req, {24'h0, got}, {24'h0, exp});
        chk(!tx_valid, "R11 reply length", {63'h0, tx_valid}, 64'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        total++;
        $display("FAIL watchdog (all requirements): actual hung expected finished");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < NREGS; i++) model[i] = 32'h0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state (R5, R8, R9, R11)
        chk(!wr_enabled, "R5 reset lock", {63'h0, wr_enabled}, 64'h0);
        chk(!chan_b, "R8 reset channel", {63'h0, chan_b}, 64'h0);
        chk(!soft_rst_req, "R9 reset request", {63'h0, soft_rst_req}, 64'h0);
        chk(!tx_valid, "R11 reset idle", {63'h0, tx_valid}, 64'h0);
        do_read(3, "R2 reset value");

        // R5: write while locked is ignored
        do_write(2, 32'h00AB_CDEF, 1'b0);
        do_read(2, "R5 locked write");

        // R7: unlock with the literal example frame
        send_byte(8'hA5); send_byte(8'hEA); send_byte(8'hE5); send_byte(8'h8B);
        model_wen = 1'b1;
        chk(wr_enabled, "R7 unlock", {63'h0, wr_enabled}, 64'h1);

        // R1: noise before sync, then R4 write
        send_byte(8'h00); send_byte(8'h5A); send_byte(8'hEA); send_byte(8'hFF);
        do_write(3, 32'h1122_3344, 1'b0);
        do_read(3, "R1 R4 write after noise");
        do_write(1, 32'h0000_BEAD, 1'b0);
        do_read(1, "R4 two-byte write");

        // R6: bad checksum write
        do_write(3, 32'hDEAD_0000, 1'b1);
        do_read(3, "R6 bad checksum write");

        // R3: unmapped reads and write
        do_write(9, 32'h0000_0077, 1'b0);
        do_read(9, "R3 unmapped read");
        do_read(8'h7F, "R3 top address read");

        // R8 and R6 on control frames
        do_special(8'hA5, 1'b0);
        chk(chan_b, "R8 select B", {63'h0, chan_b}, 64'h1);
        do_special(8'h5A, 1'b1);
        chk(chan_b, "R6 bad checksum channel", {63'h0, chan_b}, 64'h1);
        do_special(8'h5A, 1'b0);
        chk(!chan_b, "R8 select A", {63'h0, chan_b}, 64'h0);

        // R9: soft reset pulse
        send_byte(8'hA5); send_byte(8'hEA); send_byte(8'h96);
        send_byte(~(8'hA5 + 8'hEA + 8'h96));
        chk(soft_rst_req, "R9 pulse high", {63'h0, soft_rst_req}, 64'h1);
        @(negedge clk);
        chk(!soft_rst_req, "R9 pulse one cycle", {63'h0, soft_rst_req}, 64'h0);
        chk(wr_enabled, "R9 lock kept", {63'h0, wr_enabled}, 64'h1);

        // R10: stuck line abandons a half frame
        send_byte(8'hA5); send_byte(8'h81); send_byte(8'h77);
        repeat (STUCK + 10) @(negedge clk);
        do_write(1, 32'h0000_C0DE, 1'b0);
        do_read(1, "R10 resync after stuck line");
        do_read(3, "R10 registers kept");

        // R5, R7: lock again
        do_special(8'hDC, 1'b0);
        chk(!wr_enabled, "R7 lock", {63'h0, wr_enabled}, 64'h0);
        do_write(3, 32'h5555_5555, 1'b0);
        do_read(3, "R5 write after lock");

        // Random mix
        for (int it = 0; it < 300; it++) begin
            int k;
            int a;
            k = $urandom % 10;
            a = $urandom % 10;
            case (k)
                0, 1, 2: do_write(a, $urandom, ($urandom % 8) == 0);
                3, 4, 5: do_read(a, a < NREGS ? "R2 random read" : "R3 random read");
                6: do_special(8'hE5, ($urandom % 4) == 0);
                7: do_special(8'hDC, ($urandom % 4) == 0);
                8: begin
                    send_byte(8'($urandom % 165));
                    do_read(a, "R1 random noise read");
                end
                default: begin
                    do_special(8'hE5, 1'b0);
                    chk(wr_enabled == model_wen, "R7 random unlock", {63'h0, wr_enabled}, {63'h0, model_wen});
                end
            endcase
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule